// File: doc/BRIEF.md
# Four-Route DDR Pin Serializer

This block sits between core logic and a single output pin. Each half-rate cycle the core presents a four-bit word. A static two-bit route input decides how that word reaches the pin. The pin can take the word's lowest bit directly, with no register. It can take that bit through one register clocked on the full-rate rising edge. It can take a full-rate double-data-rate stream, or the whole word serialized as four consecutive half-periods of the full-rate clock. Serialization uses two half-rate DDR cells that feed one full-rate DDR cell. An output-enable travels beside the data unchanged, for use by the pad buffer that drives or floats the pin.

Two clocks drive the block. The full-rate clock runs at exactly twice the half-rate clock. Every edge of the half-rate clock coincides with a falling edge of the full-rate clock, so the full-rate cell always samples the half-rate cells mid-phase. All registers share one active-low asynchronous clear and one active-low asynchronous preset, and clear wins over preset. The data path has no handshake and no back-pressure. A word is taken at every half-rate rising edge in half-rate mode, and at every full-rate rising edge in the registered full-rate modes. The core must keep the word stable around those edges.

Top module: `ddr_pin_out`

## Requirements
- R1: With route 2'b00 (bypass), pin_val equals word_in[0] at all times, through no register.
- R2: With route 2'b01 (packed), each full-rate rising edge captures word_in[0], and pin_val holds it for the whole full-rate period that follows.
- R3: With route 2'b10 (full-rate DDR), each full-rate rising edge captures word_in[1:0]. pin_val shows bit 0 while clk_full is high and bit 1 while clk_full is low.
- R4: With route 2'b11 (half-rate DDR), each half-rate rising edge captures word_in[3:0]. Starting at the next full-rate rising edge, pin_val shows bits 0, 1, 2, 3 in four consecutive half-periods of clk_full.
- R5: While clr_n is low, every register is forced to 0, so pin_val is 0 in routes 2'b01, 2'b10 and 2'b11 without waiting for a clock edge.
- R6: While pre_n is low and clr_n is high, every register is forced to 1, so pin_val is 1 in routes 2'b01, 2'b10 and 2'b11.
- R7: When clr_n and pre_n are both low, clear wins and pin_val is 0 in every registered route.
- R8: pin_en equals oe_in in every route and reset state, and oe_in has no effect on pin_val.
- R9: In bypass, clr_n and pre_n have no effect: pin_val still equals word_in[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_half | input | 1 | Half-rate clock; its edges sit on falling edges of clk_full |
| clk_full | input | 1 | Full-rate clock, twice the frequency of clk_half |
| clr_n | input | 1 | Asynchronous clear of all registers, active low, wins over preset |
| pre_n | input | 1 | Asynchronous preset of all registers, active low |
| route | input | 2 | Static route select: 00 bypass, 01 packed, 10 full-rate DDR, 11 half-rate DDR |
| word_in | input | 4 | Parallel data word from core logic |
| oe_in | input | 1 | Output enable from the enable path |
| pin_val | output | 1 | Serial value toward the pad buffer |
| pin_en | output | 1 | Output enable toward the pad buffer; the pin floats when low |

## Verification
The word changes in every half-period of the full-rate clock, including between capture edges. This separates the edge each route samples from the values it should ignore. Checking pin_val in both clock phases shows whether the high and low halves of each DDR cell come out in the right order, and whether the serialized word keeps the order 0, 1, 2, 3. Clear, preset and both together are applied in bypass and in registered routes. This shows which routes they reach and that clear wins. The enable is toggled during a serialized stream to show that it leaves the data untouched.

// File: rtl/ddr_pin_out_pkg.sv
`timescale 1ns/1ps
package ddr_pin_out_pkg;
  typedef enum logic [1:0] {
    ROUTE_BYPASS   = 2'b00,
    ROUTE_PACKED   = 2'b01,
    ROUTE_FULL_DDR = 2'b10,
    ROUTE_HALF_DDR = 2'b11
  } route_e;

  // register value forced by the asynchronous controls; clear dominates
  function automatic logic forced_level(input logic clr_n);
    return clr_n;
  endfunction
endpackage

// File: rtl/ddr_cell.sv
`timescale 1ns/1ps
// Double-data-rate output cell: both data bits are captured on the rising
// edge; the output shows the rise bit while clk is high, the fall bit while
// low. single_edge pins the output to the rise register (plain register use).
module ddr_cell #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         pre_n,
  input  logic         single_edge,
  input  logic [W-1:0] d_rise,
  input  logic [W-1:0] d_fall,
  output logic [W-1:0] q
);
  import ddr_pin_out_pkg::*;

  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
    if (!clr_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (!pre_n) begin
      rise_q <= {W{forced_level(clr_n)}};
      fall_q <= {W{forced_level(clr_n)}};
    end else begin
      rise_q <= d_rise;
      fall_q <= d_fall;
    end
  end

  always_comb begin
    if (single_edge || clk) q = rise_q;
    else                    q = fall_q;
  end
endmodule

// File: rtl/ddr_half_stage.sv
`timescale 1ns/1ps
// Half-rate stage: one DDR cell per full-rate stream. Stream s carries word
// bit s in the high half of clk_half and bit s+STREAMS in the low half.
module ddr_half_stage #(
  parameter int STREAMS = 2,
  localparam int WORD_W = 2 * STREAMS
) (
  input  logic               clk_half,
  input  logic               clr_n,
  input  logic               pre_n,
  input  logic [WORD_W-1:0]  word,
  output logic [STREAMS-1:0] stream
);
  for (genvar g = 0; g < STREAMS; g++) begin : g_lane
    ddr_cell #(.W(1)) u_cell (
      .clk         (clk_half),
      .clr_n       (clr_n),
      .pre_n       (pre_n),
      .single_edge (1'b0),
      .d_rise      (word[g]),
      .d_fall      (word[g+STREAMS]),
      .q           (stream[g])
    );
  end
endmodule

// File: rtl/ddr_route_sel.sv
`timescale 1ns/1ps
// Bypass multiplexers: choose what feeds the full-rate cell and what reaches the pin.
module ddr_route_sel (
  input  logic [1:0] route,
  input  logic [1:0] word_lo,
  input  logic [1:0] stream,
  input  logic       full_q,
  output logic       feed_rise,
  output logic       feed_fall,
  output logic       single_edge,
  output logic       pin_val
);
  import ddr_pin_out_pkg::*;

  route_e sel;
  assign sel = route_e'(route);

  always_comb begin
    feed_rise   = word_lo[0];
    feed_fall   = word_lo[1];
    single_edge = 1'b0;
    pin_val     = full_q;
    unique case (sel)
      ROUTE_BYPASS:   pin_val     = word_lo[0];
      ROUTE_PACKED:   single_edge = 1'b1;
      ROUTE_FULL_DDR: ;
      ROUTE_HALF_DDR: begin
        feed_rise = stream[0];
        feed_fall = stream[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_pin_out.sv
`timescale 1ns/1ps
module ddr_pin_out #(
  parameter int WORD_W = 4,
  localparam int STREAMS = WORD_W / 2
) (
  input  logic              clk_half,
  input  logic              clk_full,
  input  logic              clr_n,
  input  logic              pre_n,
  input  logic [1:0]        route,
  input  logic [WORD_W-1:0] word_in,
  input  logic              oe_in,
  output logic              pin_val,
  output logic              pin_en
);
  logic [STREAMS-1:0] stream;
  logic feed_rise, feed_fall, single_edge, full_q;

  ddr_half_stage #(.STREAMS(STREAMS)) u_half (
    .clk_half (clk_half),
    .clr_n    (clr_n),
    .pre_n    (pre_n),
    .word     (word_in),
    .stream   (stream)
  );

  ddr_cell #(.W(1)) u_full (
    .clk         (clk_full),
    .clr_n       (clr_n),
    .pre_n       (pre_n),
    .single_edge (single_edge),
    .d_rise      (feed_rise),
    .d_fall      (feed_fall),
    .q           (full_q)
  );

  ddr_route_sel u_sel (
    .route       (route),
    .word_lo     (word_in[1:0]),
    .stream      (stream[1:0]),
    .full_q      (full_q),
    .feed_rise   (feed_rise),
    .feed_fall   (feed_fall),
    .single_edge (single_edge),
    .pin_val     (pin_val)
  );

  // the delay element is a plain pass-through; enable travels beside data
  assign pin_en = oe_in;
endmodule

// File: rtl/ddr_pin_out_chk.sv
`timescale 1ns/1ps
module ddr_pin_out_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk_half,
  input logic              clk_full,
  input logic              clr_n,
  input logic              pre_n,
  input logic [1:0]        route,
  input logic [WORD_W-1:0] word_in,
  input logic              pin_val
);
  import ddr_pin_out_pkg::*;
  localparam int STREAMS = WORD_W / 2;

  // R1
  bypass_direct_chk: assert property (@(posedge clk_full)
    (clr_n && pre_n && route == ROUTE_BYPASS) |-> (pin_val == word_in[0]));

  // R2
  packed_hold_chk: assert property (@(posedge clk_full) disable iff (!clr_n || !pre_n)
    (route == ROUTE_PACKED) |=> (route != ROUTE_PACKED || pin_val == $past(word_in[0])));

  // R3
  full_ddr_low_chk: assert property (@(posedge clk_full) disable iff (!clr_n || !pre_n)
    (route == ROUTE_FULL_DDR) |=> (route != ROUTE_FULL_DDR || pin_val == $past(word_in[1])));

  // R4
  half_ddr_order_chk: assert property (@(posedge clk_half) disable iff (!clr_n || !pre_n)
    (route == ROUTE_HALF_DDR) |=> (route != ROUTE_HALF_DDR || pin_val == $past(word_in[STREAMS])));

  // R5
  clear_zero_chk: assert property (@(posedge clk_full)
    (!clr_n && route != ROUTE_BYPASS) |-> (pin_val == 1'b0));

  // R6
  preset_one_chk: assert property (@(posedge clk_full)
    (clr_n && !pre_n && route != ROUTE_BYPASS) |-> (pin_val == 1'b1));

  // R7
  clear_wins_chk: assert property (@(posedge clk_full)
    (!clr_n && !pre_n && route != ROUTE_BYPASS) |-> (pin_val == 1'b0));

  // R9
  bypass_no_reset_chk: assert property (@(posedge clk_full)
    ((!clr_n || !pre_n) && route == ROUTE_BYPASS) |-> (pin_val == word_in[0]));
endmodule

bind ddr_pin_out ddr_pin_out_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_half (clk_half),
  .clk_full (clk_full),
  .clr_n    (clr_n),
  .pre_n    (pre_n),
  .route    (route),
  .word_in  (word_in),
  .pin_val  (pin_val)
);

// File: tb/test_ddr_pin_out.sv
`timescale 1ns/1ps
module test_ddr_pin_out;
  localparam int CLK_PERIOD = 10;
  localparam int PH         = CLK_PERIOD / 2;
  localparam int NPH        = 220;

  logic clk_full = 1'b1;
  logic clk_half = 1'b0;
  logic clr_n = 1'b1, pre_n = 1'b1, oe_in = 1'b0;
  logic [1:0] route = 2'b01;
  logic [3:0] word_in = 4'h0;
  logic pin_val, pin_en;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [3:0] hist [0:NPH-1];

  ddr_pin_out i_ddr_pin_out (
    .clk_half (clk_half), .clk_full (clk_full), .clr_n (clr_n), .pre_n (pre_n),
    .route (route), .word_in (word_in), .oe_in (oe_in),
    .pin_val (pin_val), .pin_en (pin_en)
  );

  always #(PH) clk_full = ~clk_full;
  initial begin
    #(PH);
    forever begin
      clk_half = ~clk_half;
      #(CLK_PERIOD);
    end
  end

  task automatic check(input string req, input int p, input logic act, input logic expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s phase %0d: got %b expected %b", req, p, act, expv);
    end
  endtask

  // stimulus plan: route, clear, preset per phase
  task automatic plan(input int p, output logic [1:0] r, output logic c, output logic s);
    c = 1'b1; s = 1'b1;
    if      (p < 8)   begin r = 2'b01; c = 1'b0; end
    else if (p < 32)  r = 2'b01;
    else if (p < 48)  r = 2'b00;
    else if (p < 72)  r = 2'b10;
    else if (p < 112) r = 2'b11;
    else if (p < 118) begin r = 2'b11; s = 1'b0; end
    else if (p < 130) r = 2'b11;
    else if (p < 136) begin r = 2'b10; c = 1'b0; s = 1'b0; end
    else if (p < 148) r = 2'b10;
    else if (p < 152) begin r = 2'b00; c = 1'b0; end
    else if (p < 156) begin r = 2'b00; s = 1'b0; end
    else if (p < 160) begin r = 2'b01; s = 1'b0; end
    else if (p < 176) r = 2'b01;
    else if (p < 180) begin r = 2'b11; c = 1'b0; end
    else              r = 2'b11;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [1:0] prev_r = 2'b01;
    logic prev_c = 1'b1, prev_s = 1'b1;
    int settle = 6;
    for (int p = 0; p < NPH; p++) begin
      logic [1:0] r;
      logic c, s, expv;
      plan(p, r, c, s);
      #2;
      route = r; clr_n = c; pre_n = s;
      oe_in = (p >= 80 && p < 112) ? (p % 3 != 0) : (p % 7 != 3);
      word_in = lfsr[3:0];
      hist[p] = lfsr[3:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (r != prev_r || (c && !prev_c) || (s && !prev_s)) settle = p + 6;
      prev_r = r; prev_c = c; prev_s = s;
      #2;
      check("R8", p, pin_en, oe_in);
      if (r == 2'b00) begin
        if (!c || !s) check("R9", p, pin_val, word_in[0]);
        else          check("R1", p, pin_val, word_in[0]);
      end else if (!c && !s) check("R7", p, pin_val, 1'b0);
      else if (!c)           check("R5", p, pin_val, 1'b0);
      else if (!s)           check("R6", p, pin_val, 1'b1);
      else if (p >= settle) begin
        int rr;
        rr = (p % 2 == 0) ? p : p - 1;
        case (r)
          2'b01: check("R2", p, pin_val, hist[rr-1][0]);
          2'b10: begin
            expv = (p % 2 == 0) ? hist[rr-1][0] : hist[rr-1][1];
            check("R3", p, pin_val, expv);
          end
          default: begin
            int h;
            h = p - 1 - ((p - 2) % 4);
            check((p >= 80 && p < 112) ? "R4/R8" : "R4", p, pin_val, hist[h-1][p-h-1]);
          end
        endcase
      end
      #1;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule